// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple memory-mapped register bus with byte-wide data. A direction register decides, pin by pin, whether the port drives the pad or listens to it. A data output register holds the value driven on output pins. Pad inputs are resynchronised before software sees them.

Data accesses go through an address window. In that window the address itself carries a per-pin select mask. Software can therefore set, clear or sample any subset of pins with a single access, and never needs a read-modify-write sequence. The bus is a single-cycle select/write strobe. Writes take effect at the rising clock edge that samples them, and read data is presented combinationally while a read is selected.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is low at a rising edge, the direction and data output registers clear. After reset, `pad_oe` and `pad_out` are both 0, so every pin starts as an input.
- R2: The direction register is at byte offset 0x400. Bit n set to 1 makes pin n an output and 0 makes it an input. `pad_oe[n]` equals direction bit n from the edge after the write. A read of 0x400 returns the stored direction value.
- R3: Offsets 0x000 to 0x3FC with address bits 1:0 equal to 0 form the data window. Address bit n+2 is the select for pin n, so offset 4<<n reaches pin n alone.
- R4: On a data write, each selected output pin takes bit n of the write data at the sampling edge. Every pin whose select bit is clear keeps its previous `pad_out` value.
- R5: A data write leaves the stored output bit of any pin configured as an input unchanged. Switching that pin to output later shows the old value on `pad_out`.
- R6: On a data read, every bit whose select bit is clear reads as 0.
- R7: On a data read, a selected output pin returns its driven output value. A selected input pin returns its synchronised pad level.
- R8: A change on `pad_in` passes through a two-flop synchroniser. It first appears in read data after the second rising edge following the change.
- R9: Any offset other than the data window and 0x400 is unmapped, including offsets with bits 1:0 not 0 and offsets such as 0x404 or 0x800. Such an access reads as 0, and a write to it changes neither `pad_out` nor `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Read data, 0 when no read is selected |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
A corrupted output register shows on `pad_out` at the edge after the offending write. This happens whether the write had the pin deselected, the pin was an input, or the offset was unmapped, so the bench compares `pad_out` with a model after every write. A wrong direction bit appears at once on `pad_oe` and changes what a data read returns for that pin. A synchroniser with the wrong depth is caught by sampling read data after zero, one and two edges following an input change. Every select mask is swept on both writes and reads, so a mis-wired address bit appears within a single sweep.

// File: rtl/gmp_pkg.sv
// Shared types for the address-masked GPIO port.
package gmp_pkg;
    // Class of the register reached by a bus offset.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } gmp_acc_e;
endpackage

// File: rtl/gmp_decode.sv
// Address decoder: classifies a byte offset and extracts the per-pin select.
// Assumes ADDR_W > PINS + 2; the direction register sits just above the data
// window at 1 << (PINS+2), and bits 1:0 must be zero for any hit.
module gmp_decode
    import gmp_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output gmp_acc_e          kind,
    output logic [PINS-1:0]   mask
);
    localparam int               WIN_BITS = PINS + 2;
    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << WIN_BITS;

    logic aligned;
    logic in_window;

    assign aligned   = (addr[1:0] == 2'b00);
    assign in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
    assign mask      = addr[WIN_BITS-1:2];

    // Pick the register class; misaligned offsets fall out as unmapped.
    always_comb begin
        kind = ACC_NONE;
        if (aligned && in_window)     kind = ACC_DATA;
        else if (addr == DIR_ADDR)    kind = ACC_DIR;
    end
endmodule

// File: rtl/gmp_sync.sv
// Multi-stage synchroniser for the pad inputs. Assumes STAGES >= 1; each
// stage is one flop per pin, all cleared by reset.
module gmp_sync #(
    parameter int PINS   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] sync_out
);
    logic [PINS-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= pad_in;
            end
        end else begin : g_next
            // Later stages shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gmp_regs.sv
// Direction and data output registers. A data write updates only pins that
// are both selected and configured as outputs; the rest hold.
module gmp_regs #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_dir,
    input  logic            wr_data,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] out_q
);
    logic [PINS-1:0] take;

    assign take = mask & dir_q;

    // Direction register: full-byte load from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output register: merge new bits into selected output pins only.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (wr_data) out_q <= (out_q & ~take) | (wdata & take);
    end
endmodule

// File: rtl/gpio_mask_port.sv
// Eight-pin GPIO port with an address-masked data window. Single-cycle bus:
// writes land at the sampling edge, read data is combinational while a read is
// selected and zero otherwise. Pad inputs are asynchronous.
module gpio_mask_port
    import gmp_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    gmp_acc_e        kind;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] sync_in;
    logic [PINS-1:0] pin_level;
    logic            wr_dir;
    logic            wr_data;

    gmp_decode #(.PINS(PINS), .ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .mask (mask)
    );

    assign wr_dir  = bus_sel && bus_wr && (kind == ACC_DIR);
    assign wr_data = bus_sel && bus_wr && (kind == ACC_DATA);

    gmp_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_dir),
        .wr_data (wr_data),
        .mask    (mask),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .out_q   (out_q)
    );

    gmp_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .sync_out (sync_in)
    );

    // Output pins report their driven value, input pins the synced pad.
    assign pin_level = (dir_q & out_q) | (~dir_q & sync_in);

    // Read mux: masked pin levels, direction readback, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (kind)
                ACC_DATA: bus_rdata = pin_level & mask;
                ACC_DIR:  bus_rdata = dir_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
// Port-level checker for gpio_mask_port; decodes offsets independently.
module gpio_mask_port_chk #(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe
);
    localparam int               TOP_BIT  = PINS + 2;
    localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << TOP_BIT;

    logic            hit_dir;
    logic            hit_data;
    logic [PINS-1:0] sel_pins;

    assign hit_dir  = (bus_addr == DIR_OFS);
    assign hit_data = (bus_addr < DIR_OFS) && (bus_addr[1:0] == 2'b00);
    assign sel_pins = bus_addr[TOP_BIT-1:2];

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0));

    a_r2_dir_write_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_dir) |=> (pad_oe == $past(bus_wdata)));

    a_r2_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && hit_dir) |-> (bus_rdata == pad_oe));

    a_r4_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_data) |=>
        (((pad_out ^ $past(pad_out)) & ~$past(sel_pins)) == '0));

    a_r5_input_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0));

    a_r6_masked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && hit_data) |-> ((bus_rdata & ~sel_pins) == '0));

    a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !hit_data && !hit_dir) |-> (bus_rdata == '0));

    a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !hit_data && !hit_dir) |=>
        ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [7:0] mdir = '0;
    logic [7:0] mout = '0;

    always #2.5 clk = ~clk;

    gpio_mask_port u_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_dir(input logic [7:0] d);
        bus_write(12'h400, d);
        mdir = d;
    endtask

    // Model of a data write with pin mask m.
    task automatic data_write(input logic [7:0] m, input logic [7:0] d);
        bus_write({2'b00, m, 2'b00}, d);
        mout = (mout & ~(m & mdir)) | (d & m & mdir);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        bus_read(12'h400, rd);
        check("R1 dir read", rd, 8'h00);

        // R2: every direction value drives pad_oe and reads back
        for (int d = 0; d < 256; d++) begin
            set_dir(8'(d));
            check("R2 pad_oe", pad_oe, 8'(d));
            bus_read(12'h400, rd);
            check("R2 dir readback", rd, 8'(d));
        end

        // R3: single-pin offsets reach one pin only
        set_dir(8'hFF);
        data_write(8'hFF, 8'h00);
        for (int n = 0; n < 8; n++) begin
            bus_write(12'(4 << n), 8'hFF);
            check("R3 single pin set", pad_out, 8'(1 << n));
            bus_write(12'(4 << n), 8'h00);
            mout = 8'h00;
            check("R3 single pin clear", pad_out, 8'h00);
        end

        // R4: all masks on output pins, unselected pins hold
        for (int m = 0; m < 256; m++) begin
            data_write(8'(m), 8'((m * 37 + 11) & 8'hFF));
            check("R4 masked write", pad_out, mout);
            if ((m % 16) == 0) begin
                bus_read(12'h3FC, rd);
                check("R7 output readback", rd, mout);
            end
        end

        // R5: writes to input pins do not reach the output register
        data_write(8'hFF, 8'h5A);
        check("R5 baseline", pad_out, 8'h5A);
        set_dir(8'h0F);
        data_write(8'hFF, 8'hA5);
        check("R5 input pins held", pad_out, 8'h55);
        set_dir(8'hFF);
        check("R5 old value after dir switch", pad_out, 8'h55);

        // R6 and R7: mixed directions, all read masks
        set_dir(8'hA5);
        data_write(8'hFF, 8'h6C);
        @(negedge clk) pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        for (int m = 0; m < 256; m++) begin
            bus_read({2'b00, 8'(m), 2'b00}, rd);
            check("R6 R7 masked read", rd,
                  8'(m) & ((mdir & mout) | (~mdir & 8'h3C)));
        end

        // R8: two-edge synchroniser latency
        set_dir(8'h00);
        repeat (3) @(negedge clk);
        @(negedge clk);
        pad_in = 8'hC3; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3FC;
        #1 check("R8 zero edges", bus_rdata, 8'h3C);
        @(negedge clk); #1 check("R8 one edge", bus_rdata, 8'h3C);
        @(negedge clk); #1 check("R8 two edges", bus_rdata, 8'hC3);

        // R9: unmapped offsets read zero and ignore writes
        set_dir(8'hF0);
        data_write(8'hFF, 8'h90);
        begin
            logic [11:0] bad [6] = '{12'h404, 12'h408, 12'h800, 12'hC00, 12'h001, 12'h402};
            foreach (bad[i]) begin
                bus_write(bad[i], 8'hFF);
                check("R9 pad_out untouched", pad_out, mout);
                check("R9 pad_oe untouched", pad_oe, mdir);
                bus_read(bad[i], rd);
                check("R9 unmapped read", rd, 8'h00);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule